// File: doc/BRIEF.md
# Two-Level Address Translation Walker

This block turns a 32-bit I/O virtual address into a physical address by fetching page-table entries from memory. A client presents an address together with the current table base. The walker reads the first-level descriptor. That descriptor either maps a 1 MiB region outright or points at a 256-entry second-level table. In the second case the walker reads one more descriptor, which maps a 64 KiB or a 4 KiB page.

Each walk ends with a single-cycle result strobe. The strobe carries the physical address, or a fault flag with the faulting virtual address and the level at which the walk stopped. Memory is reached through a plain read port: the request waits for a ready, and one data beat returns for each accepted request. Only one walk is in flight at a time.

Top module: `ptw_walker`

## Requirements
- R1: The first memory read of a walk goes to address `base + va[31:20]*4`, where `base` is the table base captured when the request was accepted.
- R2: A first-level descriptor whose bits [1:0] are 2'b10 maps a section. The walk ends after that single read with pa = {desc[31:20], va[19:0]}, no fault, and level 0.
- R3: A first-level descriptor whose bits [1:0] are 2'b01 is a link. The second read goes to `(desc & 32'hFFFFFC00) + va[19:12]*4`.
- R4: A second-level descriptor whose bits [1:0] are 2'b01 maps a 64 KiB page: pa = {desc[31:16], va[15:0]}, no fault, level 1.
- R5: A second-level descriptor with bit 1 set (2'b10 or 2'b11) maps a 4 KiB page: pa = {desc[31:12], va[11:0]}, no fault, level 1.
- R6: A first-level descriptor whose bits [1:0] are 2'b00 or 2'b11 ends the walk with a fault at level 0. On any fault the reported pa is zero.
- R7: A second-level descriptor whose bits [1:0] are 2'b00 ends the walk with a fault at level 1.
- R8: Every result carries, on `res_va`, the virtual address of the request it answers. On a fault this is the faulting address.
- R9: `req_ready` is low from the cycle after a request is accepted until the cycle after `res_valid`. `res_valid` lasts exactly one cycle per request.
- R10: Changes to `tbl_base` or `req_va` after a request is accepted do not affect that walk.
- R11: A walk issues exactly one memory read for a section or a first-level fault, and exactly two otherwise. No read is issued while idle.
- R12: While `mem_req_valid` is high and `mem_req_ready` is low, the request stays asserted with an unchanged address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| tbl_base | input | 32 | First-level table base, captured on acceptance |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 32 | Byte address of the descriptor to read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | 32 | Descriptor word |
| res_valid | output | 1 | One-cycle result strobe |
| res_fault | output | 1 | Walk ended in a fault |
| res_lvl | output | 1 | Level of the last descriptor read (0 first, 1 second) |
| res_pa | output | 32 | Translated physical address (zero on fault) |
| res_va | output | 32 | Virtual address of the walk being answered |

## Verification
The hardest case to reach from the ports is a walk whose inputs move underneath it. Here the table base and the virtual address change while the memory port is stalling a request that is still pending. The bench's memory model holds `mem_req_ready` low for a programmable number of cycles. During that window the bench drives a different base that points at a table with a conflicting mapping, and it scrambles `req_va`. Any leak of the live inputs into the walk then shows up as a wrong read address or a wrong translation. The pattern is repeated with random stall lengths across every descriptor type, including both encodings of a small page and both first-level fault encodings.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

    localparam int ADDR_W     = 32;
    localparam int SECT_LSB   = 20;   // 1 MiB region
    localparam int LPAGE_LSB  = 16;   // 64 KiB page
    localparam int SPAGE_LSB  = 12;   // 4 KiB page
    localparam int L2_ALIGN   = 10;   // second-level table alignment
    localparam int DESC_BYTES = 4;
    localparam int DESC_SH    = $clog2(DESC_BYTES);
    localparam int L1_IDX_W   = ADDR_W - SECT_LSB;
    localparam int L2_IDX_W   = SECT_LSB - SPAGE_LSB;

    typedef logic [ADDR_W-1:0] addr_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1_REQ,
        ST_L1_WAIT,
        ST_L2_REQ,
        ST_L2_WAIT,
        ST_RESP
    } walk_state_e;

    typedef enum logic [1:0] {
        KIND_FAULT,
        KIND_LINK,
        KIND_LEAF
    } desc_kind_e;

    typedef struct packed {
        desc_kind_e kind;
        addr_t      pa;
        addr_t      next_base;
    } desc_dec_t;

    function automatic addr_t splice(input addr_t hi_src, input addr_t lo_src, input int lsb);
        addr_t m;
        m = (addr_t'(1) << lsb) - addr_t'(1);
        return (hi_src & ~m) | (lo_src & m);
    endfunction

endpackage

// File: rtl/ptw_entry_decode.sv
module ptw_entry_decode
    import ptw_pkg::*;
#(
    parameter int LEVEL = 1
) (
    input  addr_t     desc,
    input  addr_t     va,
    output desc_dec_t dec
);
    localparam addr_t L2_MASK = ~((addr_t'(1) << L2_ALIGN) - addr_t'(1));

    generate
        if (LEVEL == 1) begin : g_first
            always_comb begin
                dec = '{kind: KIND_FAULT, pa: '0, next_base: '0};
                unique case (desc[1:0])
                    2'b10: begin
                        dec.kind = KIND_LEAF;
                        dec.pa   = splice(desc, va, SECT_LSB);
                    end
                    2'b01: begin
                        dec.kind      = KIND_LINK;
                        dec.next_base = desc & L2_MASK;
                    end
                    default: dec.kind = KIND_FAULT;
                endcase
            end
        end else begin : g_second
            always_comb begin
                dec = '{kind: KIND_FAULT, pa: '0, next_base: '0};
                if (desc[1]) begin
                    dec.kind = KIND_LEAF;
                    dec.pa   = splice(desc, va, SPAGE_LSB);
                end else if (desc[0]) begin
                    dec.kind = KIND_LEAF;
                    dec.pa   = splice(desc, va, LPAGE_LSB);
                end
            end
        end
    endgenerate

endmodule

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen
    import ptw_pkg::*;
(
    input  logic  second,
    input  addr_t l1_base,
    input  addr_t l2_base,
    input  addr_t va,
    output addr_t addr
);
    addr_t l1_off;
    addr_t l2_off;

    always_comb begin
        l1_off = addr_t'(va[ADDR_W-1:SECT_LSB]) << DESC_SH;
        l2_off = addr_t'(va[SECT_LSB-1:SPAGE_LSB]) << DESC_SH;
        addr   = second ? (l2_base + l2_off) : (l1_base + l1_off);
    end

endmodule

// File: rtl/ptw_fsm.sv
module ptw_fsm
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  addr_t       req_va,
    input  addr_t       tbl_base,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  desc_dec_t   l1_dec,
    input  desc_dec_t   l2_dec,
    output walk_state_e state,
    output addr_t       va_q,
    output addr_t       l1_base_q,
    output addr_t       l2_base_q,
    output addr_t       pa_q,
    output logic        fault_q,
    output logic        lvl_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            va_q      <= '0;
            l1_base_q <= '0;
            l2_base_q <= '0;
            pa_q      <= '0;
            fault_q   <= 1'b0;
            lvl_q     <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    va_q      <= req_va;
                    l1_base_q <= tbl_base;
                    state     <= ST_L1_REQ;
                end
                ST_L1_REQ: if (mem_req_ready) state <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    lvl_q <= 1'b0;
                    unique case (l1_dec.kind)
                        KIND_LEAF: begin
                            pa_q    <= l1_dec.pa;
                            fault_q <= 1'b0;
                            state   <= ST_RESP;
                        end
                        KIND_LINK: begin
                            l2_base_q <= l1_dec.next_base;
                            state     <= ST_L2_REQ;
                        end
                        default: begin
                            pa_q    <= '0;
                            fault_q <= 1'b1;
                            state   <= ST_RESP;
                        end
                    endcase
                end
                ST_L2_REQ: if (mem_req_ready) state <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    lvl_q   <= 1'b1;
                    state   <= ST_RESP;
                    fault_q <= (l2_dec.kind != KIND_LEAF);
                    pa_q    <= (l2_dec.kind == KIND_LEAF) ? l2_dec.pa : '0;
                end
                ST_RESP: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_va,
    input  logic [31:0] tbl_base,
    output logic        mem_req_valid,
    input  logic        mem_req_ready,
    output logic [31:0] mem_req_addr,
    input  logic        mem_rsp_valid,
    input  logic [31:0] mem_rsp_data,
    output logic        res_valid,
    output logic        res_fault,
    output logic        res_lvl,
    output logic [31:0] res_pa,
    output logic [31:0] res_va
);
    walk_state_e state;
    addr_t       va_q, l1_base_q, l2_base_q, pa_q;
    logic        fault_q, lvl_q;
    desc_dec_t   l1_dec, l2_dec;

    ptw_entry_decode #(.LEVEL(1)) u_dec_l1 (
        .desc (mem_rsp_data),
        .va   (va_q),
        .dec  (l1_dec)
    );

    ptw_entry_decode #(.LEVEL(2)) u_dec_l2 (
        .desc (mem_rsp_data),
        .va   (va_q),
        .dec  (l2_dec)
    );

    ptw_addr_gen u_addr (
        .second  (state == ST_L2_REQ),
        .l1_base (l1_base_q),
        .l2_base (l2_base_q),
        .va      (va_q),
        .addr    (mem_req_addr)
    );

    ptw_fsm u_fsm (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_va        (req_va),
        .tbl_base      (tbl_base),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .l1_dec        (l1_dec),
        .l2_dec        (l2_dec),
        .state         (state),
        .va_q          (va_q),
        .l1_base_q     (l1_base_q),
        .l2_base_q     (l2_base_q),
        .pa_q          (pa_q),
        .fault_q       (fault_q),
        .lvl_q         (lvl_q)
    );

    assign req_ready     = (state == ST_IDLE);
    assign mem_req_valid = (state == ST_L1_REQ) || (state == ST_L2_REQ);
    assign res_valid     = (state == ST_RESP);
    assign res_fault     = fault_q;
    assign res_lvl       = lvl_q;
    assign res_pa        = pa_q;
    assign res_va        = va_q;

endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic [31:0] req_va,
    input logic [31:0] tbl_base,
    input logic        mem_req_valid,
    input logic        mem_req_ready,
    input logic [31:0] mem_req_addr,
    input logic        mem_rsp_valid,
    input logic [31:0] mem_rsp_data,
    input logic        res_valid,
    input logic        res_fault,
    input logic        res_lvl,
    input logic [31:0] res_pa,
    input logic [31:0] res_va
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)); // R12
    AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R9
    AST_BUSY_AT_RESULT: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !req_ready); // R9
    AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (rst)
        req_valid && req_ready |=> mem_req_valid && !req_ready); // R11
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !mem_req_valid); // R11
    AST_FAULT_PA_ZERO: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_fault |-> res_pa == 32'h0); // R6
endmodule

bind ptw_walker ptw_walker_chk u_chk (.*);

// File: tb/tb_ptw_walker.sv
module tb_ptw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_va = '0;
    logic [31:0] tbl_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        res_valid, res_fault, res_lvl;
    logic [31:0] res_pa, res_va;

    int checks = 0;
    int errors = 0;
    int stall_cfg = 0;
    int reads = 0;
    bit busy = 0;
    logic [31:0] mem_q [int unsigned];
    logic [31:0] seen_addr [$];

    localparam logic [31:0] B1 = 32'h0010_0000;
    localparam logic [31:0] B2 = 32'h0020_0000;

    always #2 clk = ~clk;

    ptw_walker dut (.*);

    function automatic logic [31:0] rd(input logic [31:0] a);
        if (mem_q.exists(a)) return mem_q[a];
        return 32'h0;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // Memory model: driven and sampled on the falling edge only.
    initial begin
        int  wcnt = 0;
        bit  seen = 0;
        logic [31:0] held = '0, cap = '0;
        forever begin
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            if (mem_req_ready) begin
                mem_req_ready = 1'b0;
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(cap);
                reads++;
                seen_addr.push_back(cap);
                seen = 0;
            end else if (mem_req_valid) begin
                if (seen) chk(mem_req_addr == held, "R12", "stalled address", mem_req_addr, held);
                seen = 1;
                held = mem_req_addr;
                if (wcnt >= stall_cfg) begin
                    mem_req_ready = 1'b1;
                    cap  = mem_req_addr;
                    wcnt = 0;
                end else wcnt++;
            end
        end
    end

    // Per-clock monitor: no acceptance while a walk is in flight.
    initial forever begin
        @(negedge clk);
        if (busy && req_ready) chk(1'b0, "R9", "req_ready during walk", 32'(req_ready), 32'h0);
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    task automatic do_walk(input logic [31:0] va, input logic [31:0] base,
                           input int stall, input bit scramble);
        logic [31:0] d1, d2, a1, a2, epa;
        bit          efault, elvl;
        int          enr, n;
        string       tag;
        a1 = base + {20'h0, va[31:20], 2'b00};
        d1 = rd(a1);
        a2 = '0;
        efault = 0; elvl = 0; epa = 0; enr = 1;
        if (d1[1:0] == 2'b10) begin
            epa = {d1[31:20], va[19:0]}; tag = "R2";
        end else if (d1[1:0] == 2'b01) begin
            a2  = (d1 & 32'hFFFFFC00) + {22'h0, va[19:12], 2'b00};
            d2  = rd(a2);
            enr = 2; elvl = 1;
            if (d2[1]) begin epa = {d2[31:12], va[11:0]}; tag = "R5"; end
            else if (d2[0]) begin epa = {d2[31:16], va[15:0]}; tag = "R4"; end
            else begin efault = 1; tag = "R7"; end
        end else begin
            efault = 1; tag = "R6";
        end

        stall_cfg = stall;
        reads = 0;
        seen_addr.delete();
        @(negedge clk);
        req_valid = 1'b1; req_va = va; tbl_base = base;
        @(negedge clk);
        req_valid = 1'b0;
        busy = 1;
        if (scramble) begin
            tbl_base = (base == B1) ? B2 : B1; // R10
            req_va   = ~va;
        end
        n = 0;
        while (!res_valid && n < 400) begin @(negedge clk); n++; end
        chk(res_valid, "R9", "result strobe", 32'(res_valid), 32'h1);
        busy = 0;
        chk(res_fault == efault, tag, "fault flag", 32'(res_fault), 32'(efault));
        chk(res_lvl == elvl, tag, "level", 32'(res_lvl), 32'(elvl));
        chk(res_pa == epa, scramble ? "R10" : tag, "physical address", res_pa, epa);
        chk(res_va == va, "R8", "reported va", res_va, va);
        chk(reads == enr, "R11", "read count", reads, enr);
        if (seen_addr.size() >= 1) chk(seen_addr[0] == a1, "R1", "first read address", seen_addr[0], a1);
        if (enr == 2 && seen_addr.size() == 2) chk(seen_addr[1] == a2, "R3", "second read address", seen_addr[1], a2);
        @(negedge clk);
        chk(!res_valid, "R9", "strobe single cycle", 32'(res_valid), 32'h0);
        chk(req_ready, "R9", "ready after result", 32'(req_ready), 32'h1);
    endtask

    initial begin
        mem_q[B1 + 32'h123*4] = 32'hABC0_0002;
        mem_q[B2 + 32'h123*4] = 32'h1110_0002;
        mem_q[B1 + 32'h246*4] = 32'h0040_07FD;
        mem_q[B2 + 32'h246*4] = 32'h0000_0002;
        mem_q[B1 + 32'h7FF*4] = 32'hFFFF_FFFF;
        mem_q[32'h0040_0628]  = 32'h5555_0001;
        mem_q[32'h0040_040C]  = 32'h7777_7002;
        mem_q[32'h0040_0410]  = 32'h8888_8003;
        for (int i = 16; i < 64; i++) mem_q[32'h0040_0400 + i*4] = $urandom();

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready, "R9", "reset ready", 32'(req_ready), 32'h1);
        chk(!res_valid, "R9", "reset strobe", 32'(res_valid), 32'h0);
        chk(!mem_req_valid, "R11", "reset read", 32'(mem_req_valid), 32'h0);

        do_walk(32'h1234_5678, B1, 0, 0);   // R2 section
        do_walk(32'h2468_ACE0, B1, 0, 0);   // R4 large page
        do_walk(32'h2460_3ABC, B1, 1, 0);   // R5 small, 2'b10
        do_walk(32'h2460_4123, B1, 2, 0);   // R5 small, 2'b11
        do_walk(32'h2460_5000, B1, 0, 0);   // R7 second-level fault
        do_walk(32'h0010_0000, B1, 0, 0);   // R6 fault 2'b00
        do_walk(32'h7FF0_0ABC, B1, 3, 0);   // R6 fault 2'b11
        do_walk(32'h1234_5678, B1, 4, 1);   // R10 base moves mid-walk
        do_walk(32'h2468_ACE0, B1, 4, 1);   // R10 two-level walk
        do_walk(32'h1230_0001, B2, 0, 0);   // R2 other table
        for (int k = 0; k < 40; k++) begin
            logic [31:0] v;
            logic [11:0] idx [4] = '{12'h123, 12'h246, 12'h001, 12'h7FF};
            v = {idx[$urandom_range(3)], 20'($urandom())};
            do_walk(v, B1, $urandom_range(3), 1'($urandom()));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule